// File: doc/BRIEF.md
# Loadable Microsecond Timestamp Counter

This block keeps a 64-bit timestamp that counts whole microseconds since reset or since the last time the host loaded it. The microsecond rate comes either from a one-cycle tick supplied by a neighbouring block or from an internal clock divider; a parameter picks which. The count is a plain binary number and wraps modulo 2^64.

The host reaches the block through a 32-bit register port with four word addresses. Two words stage a new value, and two words return the running count. Only 31 bits of the upper half can be staged, because the top bit of the upper staging word is a command, not data. To load, the host writes the lower staging word, then writes the upper staging word with its top bit set, then writes it again with the top bit clear. Only a 0-to-1 change of that stored command bit loads the counter. Reading the lower running word also captures the upper half. A later read of the upper running word therefore matches the lower word, even if the count has carried in between.

Top module: `usec_stamp_counter`

## Requirements
- R1: After reset the timestamp, the read data, both staging words and the stored command bit are all zero.
- R2: In a cycle with a microsecond tick and no load, the timestamp becomes its previous value plus one, modulo 2^64, and a carry from the lower 32 bits reaches the upper half. In a cycle with neither a tick nor a load it holds its value.
- R3: With the internal divider selected (USE_EXT_TICK = 0), the count advances once every CLKS_PER_US clock cycles. The first advance falls on the CLKS_PER_US-th rising edge after reset is released.
- R4: A write to address 0 (lower staging word) stores the 32-bit value and leaves the timestamp unchanged.
- R5: A write to address 1 (upper staging word) with bit 31 set, while the stored command bit is 0, loads the timestamp at that clock edge. The value loaded has bits 62:32 from write bits 30:0 and bits 31:0 from the lower staging word. A load wins over a tick in the same cycle.
- R6: A write to address 1 with bit 31 clear does not load. A write with bit 31 set while the stored command bit is already 1 does not load either. Each such write updates the stored command bit.
- R7: A load always leaves timestamp bit 63 at 0.
- R8: The read data changes one cycle after a read request. A read of address 2 returns timestamp bits 31:0 and captures bits 63:32 at the same edge. A read of address 3 returns the captured upper half, not the live one.
- R9: A read of address 0 returns the lower staging word. A read of address 1 returns the stored command bit in bit 31 and the staged upper bits in bits 30:0. The read data holds its value in cycles without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick_i | input | 1 | One-cycle microsecond pulse, used when USE_EXT_TICK = 1 |
| wr_en_i | input | 1 | Register write request |
| wr_addr_i | input | 2 | Write word address (0 lower stage, 1 upper stage and command) |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 2 | Read word address (0, 1 staging; 2 live lower, 3 captured upper) |
| rd_data_o | output | 32 | Read data, valid the cycle after the request |
| stamp_o | output | 64 | Current timestamp |

## Verification
The assertions check on every cycle the step-or-hold rule of the counter, the loaded value and its zero top bit, the one-load-per-rising-edge rule of the command bit, the divider range, and that the upper read returns the captured half. Only the bench scenarios can show that the host sequence works end to end. They show the carry across the word boundary between a lower read and an upper read, that a load beats a tick in the same cycle, and that a repeated set command is ignored. They also show the exact cycle at which the divider first advances.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int STAMP_W   = 64;
  localparam int WORD_W    = 32;
  localparam int HI_LOAD_W = WORD_W - 1;
  localparam int PAD_W     = STAMP_W - HI_LOAD_W - WORD_W;

  typedef enum logic [1:0] {
    REG_STAGE_LO = 2'd0,
    REG_STAGE_HI = 2'd1,
    REG_LIVE_LO  = 2'd2,
    REG_LIVE_HI  = 2'd3
  } stamp_reg_e;

  // next count value, wrapping modulo 2^STAMP_W
  function automatic logic [STAMP_W-1:0] stamp_step(input logic [STAMP_W-1:0] v);
    return v + STAMP_W'(1);
  endfunction

  // value installed by a load: top bit(s) forced to zero
  function automatic logic [STAMP_W-1:0] stamp_compose(
    input logic [HI_LOAD_W-1:0] hi,
    input logic [WORD_W-1:0]    lo);
    return {{PAD_W{1'b0}}, hi, lo};
  endfunction
endpackage

// File: rtl/stamp_tick_src.sv
module stamp_tick_src #(
  parameter bit USE_EXT_TICK = 1'b0,
  parameter int CLKS_PER_US  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  generate
    if (USE_EXT_TICK) begin : g_ext
      assign tick_o = ext_tick_i;
    end else begin : g_div
      logic [CW-1:0] div_q;
      logic          unused_ext_tick;
      assign unused_ext_tick = ext_tick_i;
      assign tick_o = (div_q == CW'(CLKS_PER_US - 1));

      always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + CW'(1);
      end

      // R3: divider never leaves its range
      p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(div_q) < CLKS_PER_US));
    end
  endgenerate
endmodule

// File: rtl/stamp_load_ctrl.sv
module stamp_load_ctrl
  import stamp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  output logic [WORD_W-1:0]    lo_stage_o,
  output logic [HI_LOAD_W-1:0] hi_stage_o,
  output logic                 strobe_o,
  output logic                 load_fire_o,
  output logic [STAMP_W-1:0]   load_value_o
);
  logic [WORD_W-1:0]    lo_q;
  logic [HI_LOAD_W-1:0] hi_q;
  logic                 strobe_q;
  logic                 wr_lo, wr_hi, cmd_bit;

  assign wr_lo   = wr_en_i && (stamp_reg_e'(wr_addr_i) == REG_STAGE_LO);
  assign wr_hi   = wr_en_i && (stamp_reg_e'(wr_addr_i) == REG_STAGE_HI);
  assign cmd_bit = wr_data_i[WORD_W-1];

  // load only on a 0 -> 1 change of the stored command bit
  assign load_fire_o  = wr_hi && cmd_bit && !strobe_q;
  assign load_value_o = stamp_compose(wr_data_i[HI_LOAD_W-1:0], lo_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wr_data_i;
      if (wr_hi) begin
        hi_q     <= wr_data_i[HI_LOAD_W-1:0];
        strobe_q <= cmd_bit;
      end
    end
  end

  assign lo_stage_o = lo_q;
  assign hi_stage_o = hi_q;
  assign strobe_o   = strobe_q;

  // R6: a held command bit never produces back-to-back loads
  p_single_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire_o |=> !load_fire_o);
endmodule

// File: rtl/stamp_core.sv
module stamp_core
  import stamp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [STAMP_W-1:0] load_value_i,
  output logic [STAMP_W-1:0] stamp_o
);
  logic [STAMP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_value_i;
    else if (tick_i) cnt_q <= stamp_step(cnt_q);
  end

  assign stamp_o = cnt_q;

  // R2: one step per tick, hold otherwise
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (stamp_o == $past(stamp_o) + STAMP_W'(1)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(stamp_o));
  // R5: load value lands at the load edge, regardless of tick
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (stamp_o == $past(load_value_i)));
endmodule

// File: rtl/stamp_readback.sv
module stamp_readback
  import stamp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en_i,
  input  logic [1:0]           rd_addr_i,
  input  logic [STAMP_W-1:0]   stamp_i,
  input  logic [WORD_W-1:0]    lo_stage_i,
  input  logic [HI_LOAD_W-1:0] hi_stage_i,
  input  logic                 strobe_i,
  output logic [WORD_W-1:0]    rd_data_o
);
  logic [WORD_W-1:0] rd_q;
  logic [WORD_W-1:0] snap_q;
  logic [WORD_W-1:0] rd_mux;
  logic              live_lo_rd;

  assign live_lo_rd = rd_en_i && (stamp_reg_e'(rd_addr_i) == REG_LIVE_LO);

  always_comb begin
    unique case (stamp_reg_e'(rd_addr_i))
      REG_STAGE_LO: rd_mux = lo_stage_i;
      REG_STAGE_HI: rd_mux = {strobe_i, hi_stage_i};
      REG_LIVE_LO:  rd_mux = stamp_i[WORD_W-1:0];
      REG_LIVE_HI:  rd_mux = snap_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= '0;
      snap_q <= '0;
    end else begin
      if (rd_en_i)    rd_q   <= rd_mux;
      if (live_lo_rd) snap_q <= stamp_i[STAMP_W-1:WORD_W];
    end
  end

  assign rd_data_o = rd_q;

  // R8: upper read returns the half captured by the last lower read
  p_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && stamp_reg_e'(rd_addr_i) == REG_LIVE_HI) |=> (rd_data_o == $past(snap_q)));
  // R9: read data holds without a request
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/usec_stamp_counter.sv
module usec_stamp_counter
  import stamp_pkg::*;
#(
  parameter bit USE_EXT_TICK = 1'b0,
  parameter int CLKS_PER_US  = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic               rd_en_i,
  input  logic [1:0]         rd_addr_i,
  output logic [31:0]        rd_data_o,
  output logic [63:0]        stamp_o
);
  logic                 tick;
  logic                 load_fire;
  logic [STAMP_W-1:0]   load_value;
  logic [WORD_W-1:0]    lo_stage;
  logic [HI_LOAD_W-1:0] hi_stage;
  logic                 strobe;

  stamp_tick_src #(.USE_EXT_TICK(USE_EXT_TICK), .CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(us_tick_i), .tick_o(tick));

  stamp_load_ctrl u_load (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .lo_stage_o(lo_stage), .hi_stage_o(hi_stage),
    .strobe_o(strobe), .load_fire_o(load_fire), .load_value_o(load_value));

  stamp_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load_fire),
    .load_value_i(load_value), .stamp_o(stamp_o));

  stamp_readback u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .stamp_i(stamp_o), .lo_stage_i(lo_stage), .hi_stage_i(hi_stage),
    .strobe_i(strobe), .rd_data_o(rd_data_o));

  // R7: a load never sets the top timestamp bit
  p_top_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !stamp_o[STAMP_W-1]);
endmodule

// File: tb/usec_stamp_counter_tb.sv
module usec_stamp_counter_tb;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TICK = 2'd2, OP_CHK = 2'd3;
  localparam int NV = 25;
  // {req[3:0], op[1:0], addr[1:0], data[31:0], expect[63:0]}
  localparam logic [103:0] VEC [NV] = '{
    {4'd1, OP_CHK,  2'd0, 32'h0,         64'h0},                   // R1
    {4'd2, OP_TICK, 2'd0, 32'd3,         64'h0},                   // R2
    {4'd2, OP_CHK,  2'd0, 32'h0,         64'd3},                   // R2
    {4'd8, OP_RD,   2'd2, 32'h0,         64'd3},                   // R8
    {4'd4, OP_WR,   2'd0, 32'hFFFF_FFFE, 64'h0},                   // R4
    {4'd4, OP_CHK,  2'd0, 32'h0,         64'd3},                   // R4
    {4'd9, OP_RD,   2'd0, 32'h0,         64'h0000_0000_FFFF_FFFE}, // R9
    {4'd6, OP_WR,   2'd1, 32'h0000_0012, 64'h0},                   // R6
    {4'd6, OP_CHK,  2'd0, 32'h0,         64'd3},                   // R6
    {4'd5, OP_WR,   2'd1, 32'h8000_0012, 64'h0},                   // R5
    {4'd5, OP_CHK,  2'd0, 32'h0,         64'h0000_0012_FFFF_FFFE}, // R5
    {4'd9, OP_RD,   2'd1, 32'h0,         64'h0000_0000_8000_0012}, // R9
    {4'd2, OP_TICK, 2'd0, 32'd1,         64'h0},                   // R2
    {4'd2, OP_CHK,  2'd0, 32'h0,         64'h0000_0012_FFFF_FFFF}, // R2
    {4'd6, OP_WR,   2'd1, 32'h8000_0012, 64'h0},                   // R6
    {4'd6, OP_CHK,  2'd0, 32'h0,         64'h0000_0012_FFFF_FFFF}, // R6
    {4'd2, OP_TICK, 2'd0, 32'd1,         64'h0},                   // R2
    {4'd2, OP_CHK,  2'd0, 32'h0,         64'h0000_0013_0000_0000}, // R2
    {4'd6, OP_WR,   2'd1, 32'h0000_0033, 64'h0},                   // R6
    {4'd6, OP_CHK,  2'd0, 32'h0,         64'h0000_0013_0000_0000}, // R6
    {4'd4, OP_WR,   2'd0, 32'd5,         64'h0},                   // R4
    {4'd7, OP_WR,   2'd1, 32'hFFFF_FFFF, 64'h0},                   // R7
    {4'd7, OP_CHK,  2'd0, 32'h0,         64'h7FFF_FFFF_0000_0005}, // R7
    {4'd8, OP_RD,   2'd2, 32'h0,         64'd5},                   // R8
    {4'd8, OP_RD,   2'd3, 32'h0,         64'h0000_0000_7FFF_FFFF}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_div;
  logic [63:0] stamp, stamp_div;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  usec_stamp_counter #(.USE_EXT_TICK(1'b1), .CLKS_PER_US(100)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .stamp_o(stamp));

  usec_stamp_counter #(.USE_EXT_TICK(1'b0), .CLKS_PER_US(5)) u_dut_div (
    .clk(clk), .rst_n(rst_n), .us_tick_i(1'b0), .wr_en_i(1'b0),
    .wr_addr_i(2'd0), .wr_data_i(32'h0), .rd_en_i(1'b0),
    .rd_addr_i(2'd0), .rd_data_o(rd_data_div), .stamp_o(stamp_div));

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check64(req, {32'h0, rd_data}, {32'h0, exp});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1'b1;
      @(posedge clk); @(negedge clk);
      us_tick = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R1", stamp, 64'h0);
    check64("R1", {32'h0, rd_data}, 64'h0);
    rst_n = 1'b1;
    // R3: divider by 5 -> first step at edge 5, ten steps after 50 edges
    repeat (50) @(posedge clk);
    @(negedge clk);
    check64("R3", stamp_div, 64'd10);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check64("R3", stamp_div, 64'd10);
    @(posedge clk); @(negedge clk);
    check64("R3", stamp_div, 64'd11);
    check64("R2", stamp, 64'h0); // no tick, no change

    for (int v = 0; v < NV; v++) begin
      logic [103:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d", e[103:100]);
      case (e[99:98])
        OP_WR:   wr(e[97:96], e[95:64]);
        OP_RD:   rd_chk(tag, e[97:96], e[31:0]);
        OP_TICK: tick(int'(e[95:64]));
        default: check64(tag, stamp, e[63:0]);
      endcase
    end

    // R8: capture survives a carry between the two reads
    wr(2'd1, 32'h0000_0040);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h8000_0040);
    check64("R5", stamp, 64'h0000_0040_FFFF_FFFF);
    rd_chk("R8", 2'd2, 32'hFFFF_FFFF);
    tick(1);
    check64("R2", stamp, 64'h0000_0041_0000_0000);
    rd_chk("R8", 2'd3, 32'h0000_0040);
    rd_chk("R8", 2'd2, 32'h0);
    rd_chk("R8", 2'd3, 32'h0000_0041);

    // R5: load beats a tick in the same cycle
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd100);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h8000_0001; us_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; us_tick = 1'b0;
    check64("R5", stamp, 64'h0000_0001_0000_0064);

    // R1: mid-run reset clears count, staging and command bit
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check64("R1", stamp, 64'h0);
    check64("R1", {32'h0, rd_data}, 64'h0);
    rst_n = 1'b1;
    wr(2'd1, 32'h8000_0002);
    check64("R1", stamp, 64'h0000_0002_0000_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule